// File: doc/BRIEF.md
# Transmit Credit Flow Controller

This block keeps the transmit-side credit ledger for one direction of a point-to-point link. It holds one shared adaptive pool, counted in flits, and a small packet-granular escape credit for each of six message classes on each of two escape networks. Everything starts empty after reset. Nothing is granted until the far receiver has returned credits, which it does through a 3-bit code carried in received header flits.

A packet request names a message class, a length in flits and the escape network that may be used. The request is granted in the same cycle when credits allow. The shared pool is tried first. The class's escape credit on the named network is used only when the pool cannot cover the whole packet. In any cycle with no grant, the block tells the transmitter to send an IDLE flit, so credit traffic keeps flowing even when the link carries no data.

Top module: `credit_flow_ctrl`

## Requirements
- R1: After reset the shared pool count is 0 and the error flag is 0. No request is granted until credits have been returned.
- R2: A valid request whose length does not exceed the shared pool count is granted in the same cycle with `grant_net` = 0. The pool count drops by the length at the next clock edge.
- R3: When the pool count is below the request length, the request is granted with `grant_net` = 1 (`req_esc` = 0) or 2 (`req_esc` = 1) only if that network holds an escape credit for the request's class. That one credit is consumed and the pool is left unchanged. Otherwise there is no grant.
- R4: Return codes 1, 2 and 3 add 2, 8 and 16 flits to the shared pool at the next edge.
- R5: Return code 4 adds one escape credit on network 0, and code 5 adds one on network 1, for the class given on `ret_class`. Codes 0, 6 and 7 change nothing.
- R6: The shared pool saturates at `VNA_MAX` and each escape counter saturates at `ESC_MAX`. Any return that would exceed a limit sets `err_ovf`, which stays set until reset.
- R7: A grant and a credit return in the same cycle are applied together, and the counter takes their net effect.
- R8: `idle_flit` is 1 in exactly the cycles with no grant.
- R9: A request with class 6 or 7, or with length 0, is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Packet request present |
| req_class | input | 3 | Message class of the request (0..5 valid) |
| req_len | input | LEN_W | Packet length in flits |
| req_esc | input | 1 | Escape network allowed for fallback (0 or 1) |
| grant | output | 1 | Request granted this cycle |
| grant_net | output | 2 | Network used: 0 shared, 1 escape 0, 2 escape 1 |
| idle_flit | output | 1 | Send an IDLE flit this cycle |
| ret_valid | input | 1 | Credit-return field valid |
| ret_code | input | 3 | Credit-return code |
| ret_class | input | 3 | Class for escape credit returns |
| vna_count | output | $clog2(VNA_MAX+1) | Current shared pool credit count |
| err_ovf | output | 1 | Sticky credit overflow flag |

## Verification
A wrong shared-pool count shows at the `vna_count` port one edge after the update that caused it. It also shows as a grant decision that flips at the length boundary. A lost or duplicated escape credit cannot be read directly. It shows up on the next fallback request for that class and network, as a missing or extra grant, so the bench follows every escape return with requests that drain the counter and then probe it once more. Overflow faults appear on `err_ovf` one edge after the offending return, and the bench checks that the flag stays set afterward.

// File: rtl/cfc_pkg.sv
package cfc_pkg;

  typedef enum logic [1:0] {
    NET_SHARED = 2'd0,
    NET_ESC0   = 2'd1,
    NET_ESC1   = 2'd2
  } net_e;

  typedef enum logic [2:0] {
    RET_NONE   = 3'd0,
    RET_POOL2  = 3'd1,
    RET_POOL8  = 3'd2,
    RET_POOL16 = 3'd3,
    RET_ESC0   = 3'd4,
    RET_ESC1   = 3'd5
  } ret_e;

  localparam int unsigned ADD_W = 5;

endpackage

// File: rtl/cfc_ret_decode.sv
module cfc_ret_decode #(
  parameter int unsigned NUM_CLS = 6
) (
  input  logic                            ret_valid,
  input  logic [2:0]                      ret_code,
  input  logic [2:0]                      ret_class,
  output logic [cfc_pkg::ADD_W-1:0]       pool_add,
  output logic [1:0][NUM_CLS-1:0]         esc_inc
);
  import cfc_pkg::*;

  logic cls_ok;

  always_comb begin
    cls_ok   = (32'(ret_class) < NUM_CLS);
    pool_add = '0;
    esc_inc  = '0;
    if (ret_valid) begin
      case (ret_code)
        RET_POOL2:  pool_add = ADD_W'(2);
        RET_POOL8:  pool_add = ADD_W'(8);
        RET_POOL16: pool_add = ADD_W'(16);
        default:    pool_add = '0;
      endcase
      for (int c = 0; c < NUM_CLS; c++) begin
        if (cls_ok && (32'(ret_class) == c)) begin
          esc_inc[0][c] = (ret_code == RET_ESC0);
          esc_inc[1][c] = (ret_code == RET_ESC1);
        end
      end
    end
  end

endmodule

// File: rtl/cfc_vna_pool.sv
module cfc_vna_pool #(
  parameter int unsigned VNA_MAX = 64,
  parameter int unsigned LEN_W   = 4,
  localparam int unsigned VNA_W  = $clog2(VNA_MAX + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        take_en,
  input  logic [LEN_W-1:0]            take_len,
  input  logic [cfc_pkg::ADD_W-1:0]   add_amt,
  output logic [VNA_W-1:0]            cnt,
  output logic                        ovf
);
  import cfc_pkg::*;

  localparam int unsigned SUM_W = $clog2(VNA_MAX + (1 << ADD_W) + 1);

  logic [SUM_W-1:0] sum;
  logic [VNA_W-1:0] cnt_nxt;
  logic             cnt_en;

  always_comb begin
    sum     = SUM_W'(cnt) + SUM_W'(add_amt)
              - (take_en ? SUM_W'(take_len) : SUM_W'(0));
    ovf     = 1'b0;
    cnt_nxt = sum[VNA_W-1:0];
    if (sum > SUM_W'(VNA_MAX)) begin
      cnt_nxt = VNA_W'(VNA_MAX);
      ovf     = 1'b1;
    end
    cnt_en  = take_en || (add_amt != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_nxt;
    end
  end

  // R6
  pool_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) <= VNA_MAX);

  // R2
  pool_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_en && add_amt == '0) |=> (cnt == $past(cnt) - VNA_W'($past(take_len))));

  // R4
  pool_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_en && add_amt != '0 && (32'(cnt) + 32'(add_amt) <= VNA_MAX))
      |=> (cnt == $past(cnt) + VNA_W'($past(add_amt))));

endmodule

// File: rtl/cfc_esc_cnt.sv
module cfc_esc_cnt #(
  parameter int unsigned ESC_MAX = 3,
  localparam int unsigned ESC_W  = $clog2(ESC_MAX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic avail,
  output logic ovf
);

  logic [ESC_W-1:0] cnt;
  logic [ESC_W-1:0] cnt_nxt;
  logic             cnt_en;

  always_comb begin
    cnt_nxt = cnt;
    ovf     = 1'b0;
    case ({inc, dec})
      2'b10: begin
        if (32'(cnt) == ESC_MAX) ovf = 1'b1;
        else                     cnt_nxt = cnt + ESC_W'(1);
      end
      2'b01:   cnt_nxt = cnt - ESC_W'(1);
      default: cnt_nxt = cnt;
    endcase
    cnt_en = inc ^ dec;
    avail  = (cnt != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_nxt;
    end
  end

  // R6
  esc_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) <= ESC_MAX);

  // R3
  esc_dec_needs_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (cnt != '0));

  // R7
  esc_net_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec) |=> $stable(cnt));

endmodule

// File: rtl/cfc_alloc.sv
module cfc_alloc #(
  parameter int unsigned NUM_CLS = 6,
  parameter int unsigned LEN_W   = 4,
  parameter int unsigned VNA_W   = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [2:0]              req_class,
  input  logic [LEN_W-1:0]        req_len,
  input  logic                    req_esc,
  input  logic [VNA_W-1:0]        pool_cnt,
  input  logic [1:0][NUM_CLS-1:0] esc_avail,
  output logic                    grant,
  output cfc_pkg::net_e           grant_net,
  output logic                    pool_take,
  output logic [1:0][NUM_CLS-1:0] esc_dec
);
  import cfc_pkg::*;

  logic req_ok;
  logic pool_ok;
  logic esc_hit;

  always_comb begin
    req_ok  = req_valid && (32'(req_class) < NUM_CLS) && (req_len != '0);
    pool_ok = (32'(pool_cnt) >= 32'(req_len));
    esc_hit = 1'b0;
    for (int c = 0; c < NUM_CLS; c++) begin
      if (32'(req_class) == c) esc_hit = esc_avail[req_esc][c];
    end

    grant     = 1'b0;
    grant_net = NET_SHARED;
    pool_take = 1'b0;
    esc_dec   = '0;
    if (req_ok) begin
      if (pool_ok) begin
        grant     = 1'b1;
        pool_take = 1'b1;
      end else if (esc_hit) begin
        grant     = 1'b1;
        grant_net = req_esc ? NET_ESC1 : NET_ESC0;
        for (int c = 0; c < NUM_CLS; c++) begin
          if (32'(req_class) == c) esc_dec[req_esc][c] = 1'b1;
        end
      end
    end
  end

  // R2
  alloc_pool_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && grant_net == NET_SHARED) |-> (32'(pool_cnt) >= 32'(req_len)));

  // R3
  alloc_fallback_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && grant_net != NET_SHARED) |-> (32'(pool_cnt) < 32'(req_len)));

  // R9
  alloc_legal_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (req_len != '0 && req_class < 3'd6));

  // R3
  alloc_one_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(esc_dec) <= 1);

endmodule

// File: rtl/credit_flow_ctrl.sv
module credit_flow_ctrl #(
  parameter int unsigned NUM_CLS = 6,
  parameter int unsigned LEN_W   = 4,
  parameter int unsigned VNA_MAX = 64,
  parameter int unsigned ESC_MAX = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [2:0]                   req_class,
  input  logic [LEN_W-1:0]             req_len,
  input  logic                         req_esc,
  output logic                         grant,
  output logic [1:0]                   grant_net,
  output logic                         idle_flit,
  input  logic                         ret_valid,
  input  logic [2:0]                   ret_code,
  input  logic [2:0]                   ret_class,
  output logic [$clog2(VNA_MAX+1)-1:0] vna_count,
  output logic                         err_ovf
);
  import cfc_pkg::*;

  localparam int unsigned VNA_W = $clog2(VNA_MAX + 1);

  logic [ADD_W-1:0]        pool_add;
  logic [1:0][NUM_CLS-1:0] esc_inc;
  logic [1:0][NUM_CLS-1:0] esc_dec;
  logic [1:0][NUM_CLS-1:0] esc_avail;
  logic [1:0][NUM_CLS-1:0] esc_ovf;
  logic                    pool_take;
  logic                    pool_ovf;
  net_e                    net_sel;
  logic                    err_nxt;
  logic                    err_en;

  cfc_ret_decode #(.NUM_CLS(NUM_CLS)) u_dec (
    .ret_valid (ret_valid),
    .ret_code  (ret_code),
    .ret_class (ret_class),
    .pool_add  (pool_add),
    .esc_inc   (esc_inc)
  );

  cfc_alloc #(.NUM_CLS(NUM_CLS), .LEN_W(LEN_W), .VNA_W(VNA_W)) u_alloc (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_class (req_class),
    .req_len   (req_len),
    .req_esc   (req_esc),
    .pool_cnt  (vna_count),
    .esc_avail (esc_avail),
    .grant     (grant),
    .grant_net (net_sel),
    .pool_take (pool_take),
    .esc_dec   (esc_dec)
  );

  cfc_vna_pool #(.VNA_MAX(VNA_MAX), .LEN_W(LEN_W)) u_pool (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_en  (pool_take),
    .take_len (req_len),
    .add_amt  (pool_add),
    .cnt      (vna_count),
    .ovf      (pool_ovf)
  );

  for (genvar n = 0; n < 2; n++) begin : g_net
    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
      cfc_esc_cnt #(.ESC_MAX(ESC_MAX)) u_esc (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (esc_inc[n][c]),
        .dec   (esc_dec[n][c]),
        .avail (esc_avail[n][c]),
        .ovf   (esc_ovf[n][c])
      );
    end
  end

  always_comb begin
    grant_net = net_sel;
    idle_flit = !grant;
    err_en    = pool_ovf || (esc_ovf != '0);
    err_nxt   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_ovf <= 1'b0;
    end else if (err_en) begin
      err_ovf <= err_nxt;
    end
  end

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_ovf |=> err_ovf);

  // R8
  idle_vs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({idle_flit, grant}));

  // R2
  grant_net_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (grant_net != 2'd3));

endmodule

// File: tb/tb_credit_flow_ctrl.sv
module tb_credit_flow_ctrl;

  localparam int LEN_W = 4;

  logic             clk;
  logic             rst_n;
  logic             req_valid;
  logic [2:0]       req_class;
  logic [LEN_W-1:0] req_len;
  logic             req_esc;
  logic             grant;
  logic [1:0]       grant_net;
  logic             idle_flit;
  logic             ret_valid;
  logic [2:0]       ret_code;
  logic [2:0]       ret_class;
  logic [6:0]       vna_count;
  logic             err_ovf;

  int n_chk;
  int n_fail;
  int exp_vna;

  logic       s_g;
  logic [1:0] s_net;
  logic       s_idle;

  credit_flow_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_class(req_class), .req_len(req_len), .req_esc(req_esc),
    .grant(grant), .grant_net(grant_net), .idle_flit(idle_flit),
    .ret_valid(ret_valid), .ret_code(ret_code), .ret_class(ret_class),
    .vna_count(vna_count), .err_ovf(err_ovf)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one cycle from a negedge; sample combinational grant, then pass the edge.
  task automatic step(input logic rv, input int rc, input int rl, input logic re,
                      input logic tv, input int tc, input int tcls);
    req_valid = rv; req_class = 3'(rc); req_len = LEN_W'(rl); req_esc = re;
    ret_valid = tv; ret_code = 3'(tc); ret_class = 3'(tcls);
    #1;
    s_g = grant; s_net = grant_net; s_idle = idle_flit;
    @(negedge clk);
    req_valid = 1'b0; ret_valid = 1'b0;
  endtask

  task automatic do_reset();
    req_valid = 0; req_class = 0; req_len = 0; req_esc = 0;
    ret_valid = 0; ret_code = 0; ret_class = 0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    exp_vna = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 pool zero", int'(vna_count), 0);
    chk("R1 err zero", int'(err_ovf), 0);
    step(1, 0, 1, 0, 0, 0, 0);
    chk("R1 no grant before credits", int'(s_g), 0);
    chk("R8 idle when no grant", int'(s_idle), 1);
  endtask

  task automatic t_pool_returns();
    step(0, 0, 0, 0, 1, 1, 0); exp_vna += 2;
    chk("R4 code1 +2", int'(vna_count), exp_vna);
    step(0, 0, 0, 0, 1, 2, 0); exp_vna += 8;
    chk("R4 code2 +8", int'(vna_count), exp_vna);
    step(0, 0, 0, 0, 1, 3, 0); exp_vna += 16;
    chk("R4 code3 +16", int'(vna_count), exp_vna);
    step(0, 0, 0, 0, 1, 0, 0);
    chk("R5 code0 no change", int'(vna_count), exp_vna);
    step(0, 0, 0, 0, 1, 6, 0);
    chk("R5 code6 no change", int'(vna_count), exp_vna);
    step(0, 0, 0, 0, 1, 7, 0);
    chk("R5 code7 no change", int'(vna_count), exp_vna);
  endtask

  task automatic t_pool_grant();
    step(1, 2, 9, 0, 0, 0, 0);
    chk("R2 grant len9", int'(s_g), 1);
    chk("R2 net shared", int'(s_net), 0);
    chk("R8 no idle on grant", int'(s_idle), 0);
    exp_vna -= 9;
    chk("R2 pool after len9", int'(vna_count), exp_vna);
    step(1, 0, 5, 1, 0, 0, 0);
    chk("R2 grant len5", int'(s_g), 1);
    exp_vna -= 5;
    chk("R2 pool after len5", int'(vna_count), exp_vna);
  endtask

  task automatic t_fallback();
    step(1, 1, 15, 0, 0, 0, 0);
    chk("R3 no escape credit yet", int'(s_g), 0);
    chk("R8 idle on refusal", int'(s_idle), 1);
    step(0, 0, 0, 0, 1, 4, 1);
    step(1, 2, 15, 0, 0, 0, 0);
    chk("R5 credit not given to class2", int'(s_g), 0);
    step(1, 1, 15, 1, 0, 0, 0);
    chk("R5 credit not given to net1", int'(s_g), 0);
    step(1, 1, 15, 0, 0, 0, 0);
    chk("R3 escape grant", int'(s_g), 1);
    chk("R3 net esc0", int'(s_net), 1);
    chk("R3 pool untouched", int'(vna_count), exp_vna);
    step(1, 1, 15, 0, 0, 0, 0);
    chk("R3 escape credit consumed", int'(s_g), 0);
  endtask

  task automatic t_net_effect();
    step(0, 0, 0, 0, 1, 5, 1);
    step(1, 1, 15, 1, 1, 5, 1);
    chk("R7 esc grant with return", int'(s_g), 1);
    chk("R3 net esc1", int'(s_net), 2);
    step(1, 1, 15, 1, 0, 0, 0);
    chk("R7 esc credit remains", int'(s_g), 1);
    step(1, 1, 15, 1, 0, 0, 0);
    chk("R7 esc drained", int'(s_g), 0);
    step(1, 0, 4, 0, 1, 2, 0);
    chk("R7 pool grant with return", int'(s_g), 1);
    exp_vna = exp_vna - 4 + 8;
    chk("R7 pool net", int'(vna_count), exp_vna);
  endtask

  task automatic t_illegal();
    step(1, 6, 1, 0, 0, 0, 0);
    chk("R9 class6 refused", int'(s_g), 0);
    step(1, 7, 1, 0, 0, 0, 0);
    chk("R9 class7 refused", int'(s_g), 0);
    step(1, 0, 0, 0, 0, 0, 0);
    chk("R9 len0 refused", int'(s_g), 0);
    chk("R9 pool unchanged", int'(vna_count), exp_vna);
  endtask

  task automatic t_saturate();
    do_reset();
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 3, 0);
    chk("R6 pool at max", int'(vna_count), 64);
    chk("R6 no err at max", int'(err_ovf), 0);
    step(0, 0, 0, 0, 1, 1, 0);
    chk("R6 pool saturates", int'(vna_count), 64);
    chk("R6 err set", int'(err_ovf), 1);
    step(1, 0, 4, 0, 0, 0, 0);
    chk("R6 grant after sat", int'(vna_count), 60);
    chk("R6 err sticky", int'(err_ovf), 1);
    do_reset();
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 5, 0);
    chk("R6 esc at max no err", int'(err_ovf), 0);
    step(0, 0, 0, 0, 1, 5, 0);
    chk("R6 esc overflow err", int'(err_ovf), 1);
    for (int i = 0; i < 4; i++) begin
      step(1, 0, 15, 1, 0, 0, 0);
      chk("R6 esc held max grants", int'(s_g), (i < 3) ? 1 : 0);
    end
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    t_reset();
    t_pool_returns();
    t_pool_grant();
    t_fallback();
    t_net_effect();
    t_illegal();
    t_saturate();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule